// File: doc/BRIEF.md
# Network Controller Register Window

This block holds the 32-bit registers of a network controller behind a 4 KB memory-mapped window. Each word index has a fixed access class and a fixed reset value. The class decides what a read returns and what a write does. The classes are read-write, write-only, write-one-to-clear, read-only and undefined. Only whole aligned words may be accessed, and a request the window cannot serve gets an error response. A response follows every request exactly one cycle later.

Per-ring descriptor base registers get special treatment. A write to a transmit or receive base register is aligned to eight bytes. The same aligned value is also loaded into that ring's current-pointer register on the same clock edge. The interrupt, DMA-control and status words are not stored in this block. A write to one of them comes out as a one-cycle write strobe with its data. A read of one of them returns a value supplied from outside.

The word index is the byte address shifted right by two. Index map: 0-3 external, 4-7 write-one-to-clear, 8-15 read-write, 16-19 write-only (their stored values drive `wo_val_o`), 20-23 read-only, 32-39 transmit bases, 40-47 transmit pointers, 48-55 receive bases, 56-63 receive pointers. Every other index is undefined.

Top module: `netctl_regwin`

## Requirements
- R1: A request at byte address A (with A[1:0]=0, below 0x1000) targets word index A>>2. Index i is word i of the map.
- R2: A request whose address is 0x1000 or above, whose address has A[1:0]≠0, or whose byte enables are not 4'b1111 returns rsp_err_o=1 and rsp_rdata_o=0. It changes no register and raises no strobe.
- R3: Every request (req_valid_i high at an edge) gives rsp_valid_o high for exactly the following cycle. A read carries its data there, and a write returns data 0.
- R4: Read-write words (8-15) and pointer words (40-47, 56-63) store a written value in full and read it back.
- R5: Write-only words (16-19) store a written value in full and present it on wo_val_o (word 16+k in bits 32k+31:32k), but a read of them returns 0.
- R6: A write to a write-one-to-clear word (4-7) clears exactly the bits written as 1 and leaves the others.
- R7: Read-only words (20-23) always read their reset value, and writes to them are ignored.
- R8: Undefined words (24-31, 64-1023) read 0, ignore writes, and raise no error.
- R9: After reset every word is 0 except word 4=0x800000FF, 5=0x0F0F0F0F, 6=0xFFFF0000, 8=0x00001400, 9=0x004005F2, 12=0x00000600, 20=0x01240010, 21=0x00000003, 22=0xC0DE0001.
- R10: A write of V to base word b (32-39 or 48-55) stores V with bits 2:0 cleared. The same edge loads that value into pointer word b+8.
- R11: A write to an external word s (0-3) raises spc_wr_o bit s alone, with spc_wdata_o equal to the written value, in the response cycle only. A read of s returns spc_rdata_i bits 32s+31:32s as sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (16) | Byte address |
| req_be_i | input | 4 | Byte enables, must be all ones |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_err_o | output | 1 | Request rejected |
| rsp_rdata_o | output | 32 | Read data |
| spc_wr_o | output | 4 | One-hot write strobes for external words 0-3 |
| spc_wdata_o | output | 32 | Data accompanying a strobe |
| spc_rdata_i | input | 128 | Read values of external words, word s in bits 32s+31:32s |
| wo_val_o | output | 128 | Stored values of write-only words 16-19 |

## Verification
A wrong stored value stays hidden until that word is read back. The exception is a write-only word, which shows on `wo_val_o` on the cycle after the write. The bench therefore reads every word after reset, then reads back after each directed write. During the long mixed run, every read response is compared with a behavioural model. A broken alias shows up on the first read of the pointer after a base write. A broken error path shows up as a changed word on any later read of the targeted index. Strobe and response timing errors appear in the cycle right after the request, because both outputs are compared on every clock.

// File: rtl/netctl_regwin_pkg.sv
package netctl_regwin_pkg;

    localparam int WORD_W    = 32;
    localparam int WIN_BYTES = 4096;
    localparam int IDX_W     = $clog2(WIN_BYTES / 4);

    localparam int SPC_NUM   = 4;
    localparam int W1C_BASE  = 4;
    localparam int W1C_NUM   = 4;
    localparam int RW_BASE   = 8;
    localparam int RW_NUM    = 8;
    localparam int WO_BASE   = 16;
    localparam int WO_NUM    = 4;
    localparam int RO_BASE   = 20;
    localparam int RO_NUM    = 4;
    localparam int RING_BASE = 32;
    localparam int MAX_RINGS = 8;

    localparam logic [WORD_W-1:0] BASE_MASK = 32'hFFFF_FFF8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RW,
        ACC_WO,
        ACC_W1C,
        ACC_RO,
        ACC_SPC,
        ACC_BASE,
        ACC_PTR
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        acc_e              acc;
        logic [WORD_W-1:0] wdata;
    } req_t;

    function automatic acc_e acc_of(input int idx, input int nr);
        int r;
        acc_e a;
        a = ACC_NONE;
        r = idx - RING_BASE;
        if (idx < SPC_NUM)
            a = ACC_SPC;
        else if (idx >= W1C_BASE && idx < W1C_BASE + W1C_NUM)
            a = ACC_W1C;
        else if (idx >= RW_BASE && idx < RW_BASE + RW_NUM)
            a = ACC_RW;
        else if (idx >= WO_BASE && idx < WO_BASE + WO_NUM)
            a = ACC_WO;
        else if (idx >= RO_BASE && idx < RO_BASE + RO_NUM)
            a = ACC_RO;
        else if (r >= 0 && r < 4 * nr) begin
            if ((r / nr) == 0 || (r / nr) == 2)
                a = ACC_BASE;
            else
                a = ACC_PTR;
        end
        return a;
    endfunction

    function automatic logic [WORD_W-1:0] rst_of(input int idx);
        logic [WORD_W-1:0] v;
        case (idx)
            4:       v = 32'h8000_00FF;
            5:       v = 32'h0F0F_0F0F;
            6:       v = 32'hFFFF_0000;
            8:       v = 32'h0000_1400;
            9:       v = 32'h0040_05F2;
            12:      v = 32'h0000_0600;
            20:      v = 32'h0124_0010;
            21:      v = 32'h0000_0003;
            22:      v = 32'hC0DE_0001;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/netctl_regwin_decode.sv
module netctl_regwin_decode
    import netctl_regwin_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_RINGS = 8
) (
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [3:0]        req_be_i,
    input  logic [WORD_W-1:0] req_wdata_i,
    output req_t              req_o
);

    localparam int LOW_W = IDX_W + 2;

    logic out_of_win;
    logic misaligned;
    logic partial;
    logic [IDX_W-1:0] idx;

    generate
        if (ADDR_W > LOW_W) begin : g_wide
            assign out_of_win = |req_addr_i[ADDR_W-1:LOW_W];
        end else begin : g_narrow
            assign out_of_win = 1'b0;
        end
    endgenerate

    assign misaligned = |req_addr_i[1:0];
    assign partial    = (req_be_i != 4'hF);
    assign idx        = req_addr_i[LOW_W-1:2];

    always_comb begin
        req_o.vld   = req_valid_i;
        req_o.err   = req_valid_i & (out_of_win | misaligned | partial);
        req_o.wr    = req_write_i;
        req_o.idx   = idx;
        req_o.acc   = acc_of(int'(idx), NUM_RINGS);
        req_o.wdata = req_wdata_i;
    end

endmodule

// File: rtl/netctl_regwin_store.sv
module netctl_regwin_store
    import netctl_regwin_pkg::*;
#(
    parameter int NUM_RINGS = 8,
    parameter int SPAN      = RING_BASE + 4 * NUM_RINGS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_ok_i,
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [WORD_W-1:0]            wdata_i,
    output logic [SPAN-1:0][WORD_W-1:0]  q_o
);

    logic [SPAN-1:0] we;

    always_comb begin
        for (int i = 0; i < SPAN; i++)
            we[i] = wr_ok_i && (idx_i == IDX_W'(i));
    end

    generate
        for (genvar i = 0; i < SPAN; i++) begin : g_word
            localparam acc_e             ACC = acc_of(i, NUM_RINGS);
            localparam logic [WORD_W-1:0] RST = rst_of(i);

            if (ACC == ACC_RW || ACC == ACC_WO) begin : g_plain
                always_ff @(posedge clk) begin
                    if (rst)        q_o[i] <= RST;
                    else if (we[i]) q_o[i] <= wdata_i;
                end
            end else if (ACC == ACC_W1C) begin : g_w1c
                always_ff @(posedge clk) begin
                    if (rst)        q_o[i] <= RST;
                    else if (we[i]) q_o[i] <= q_o[i] & ~wdata_i;
                end

                AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
                    we[i] |=> ((q_o[i] & $past(wdata_i)) == '0)); // R6
            end else if (ACC == ACC_BASE) begin : g_base
                always_ff @(posedge clk) begin
                    if (rst)        q_o[i] <= RST;
                    else if (we[i]) q_o[i] <= wdata_i & BASE_MASK;
                end
            end else if (ACC == ACC_PTR) begin : g_ptr
                localparam int SRC = i - NUM_RINGS;
                always_ff @(posedge clk) begin
                    if (rst)          q_o[i] <= RST;
                    else if (we[i])   q_o[i] <= wdata_i;
                    else if (we[SRC]) q_o[i] <= wdata_i & BASE_MASK;
                end

                AST_PTR_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (rst)
                    we[SRC] |=> (q_o[i] == q_o[SRC])); // R10
            end else begin : g_const
                assign q_o[i] = RST;
            end
        end
    endgenerate

endmodule

// File: rtl/netctl_regwin_rdpath.sv
module netctl_regwin_rdpath
    import netctl_regwin_pkg::*;
#(
    parameter int SPAN = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  req_t                          req_i,
    input  logic [SPAN-1:0][WORD_W-1:0]   q_i,
    input  logic [SPC_NUM*WORD_W-1:0]     spc_rdata_i,
    output logic                          rsp_valid_o,
    output logic                          rsp_err_o,
    output logic [WORD_W-1:0]             rsp_rdata_o,
    output logic [SPC_NUM-1:0]            spc_wr_o,
    output logic [WORD_W-1:0]             spc_wdata_o
);

    logic [WORD_W-1:0]  rd_d;
    logic [SPC_NUM-1:0] strobe_d;
    logic               is_read;

    assign is_read = req_i.vld && !req_i.err && !req_i.wr;

    always_comb begin
        rd_d = '0;
        if (is_read) begin
            case (req_i.acc)
                ACC_RW, ACC_W1C, ACC_RO, ACC_BASE, ACC_PTR: begin
                    for (int i = 0; i < SPAN; i++)
                        if (req_i.idx == IDX_W'(i)) rd_d = q_i[i];
                end
                ACC_SPC: begin
                    for (int s = 0; s < SPC_NUM; s++)
                        if (req_i.idx == IDX_W'(s)) rd_d = spc_rdata_i[s*WORD_W +: WORD_W];
                end
                default: rd_d = '0;
            endcase
        end
    end

    always_comb begin
        for (int s = 0; s < SPC_NUM; s++)
            strobe_d[s] = req_i.vld && req_i.wr && !req_i.err && (req_i.idx == IDX_W'(s));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
            spc_wr_o    <= '0;
            spc_wdata_o <= '0;
        end else begin
            rsp_valid_o <= req_i.vld;
            rsp_err_o   <= req_i.err;
            rsp_rdata_o <= rd_d;
            spc_wr_o    <= strobe_d;
            spc_wdata_o <= (|strobe_d) ? req_i.wdata : '0;
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_i.vld |=> rsp_valid_o); // R3
    AST_RSP_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_i.vld |=> !rsp_valid_o); // R3
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err_o |-> (rsp_rdata_o == '0 && spc_wr_o == '0)); // R2
    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_read && req_i.acc == ACC_WO) |=> (rsp_rdata_o == '0)); // R5
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spc_wr_o)); // R11

endmodule

// File: rtl/netctl_regwin.sv
module netctl_regwin
    import netctl_regwin_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_RINGS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid_i,
    input  logic                      req_write_i,
    input  logic [ADDR_W-1:0]         req_addr_i,
    input  logic [3:0]                req_be_i,
    input  logic [31:0]               req_wdata_i,
    output logic                      rsp_valid_o,
    output logic                      rsp_err_o,
    output logic [31:0]               rsp_rdata_o,
    output logic [SPC_NUM-1:0]        spc_wr_o,
    output logic [31:0]               spc_wdata_o,
    input  logic [SPC_NUM*32-1:0]     spc_rdata_i,
    output logic [WO_NUM*32-1:0]      wo_val_o
);

    localparam int SPAN = RING_BASE + 4 * NUM_RINGS;

    req_t                        dec_q;
    logic [SPAN-1:0][WORD_W-1:0] reg_q;
    logic                        wr_ok;

    netctl_regwin_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_RINGS (NUM_RINGS)
    ) u_decode (
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_be_i    (req_be_i),
        .req_wdata_i (req_wdata_i),
        .req_o       (dec_q)
    );

    assign wr_ok = dec_q.vld && dec_q.wr && !dec_q.err;

    netctl_regwin_store #(
        .NUM_RINGS (NUM_RINGS),
        .SPAN      (SPAN)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_ok_i (wr_ok),
        .idx_i   (dec_q.idx),
        .wdata_i (dec_q.wdata),
        .q_o     (reg_q)
    );

    netctl_regwin_rdpath #(
        .SPAN (SPAN)
    ) u_rdpath (
        .clk         (clk),
        .rst         (rst),
        .req_i       (dec_q),
        .q_i         (reg_q),
        .spc_rdata_i (spc_rdata_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_err_o   (rsp_err_o),
        .rsp_rdata_o (rsp_rdata_o),
        .spc_wr_o    (spc_wr_o),
        .spc_wdata_o (spc_wdata_o)
    );

    generate
        for (genvar w = 0; w < WO_NUM; w++) begin : g_wo
            assign wo_val_o[w*32 +: 32] = reg_q[WO_BASE + w];
        end
    endgenerate

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (dec_q.vld && dec_q.err) |=> $stable(reg_q)); // R2
    AST_ERR_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        (dec_q.vld && dec_q.err) |=> (rsp_err_o && rsp_valid_o)); // R2

endmodule

// File: tb/netctl_regwin_tb.sv
`timescale 1ns/1ps
module netctl_regwin_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [3:0]   req_be = 4'hF;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_err;
    logic [31:0]  rsp_rdata;
    logic [3:0]   spc_wr;
    logic [31:0]  spc_wdata;
    logic [127:0] spc_rdata;
    logic [127:0] wo_val;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    assign spc_rdata = {32'h5A5A_0003, 32'hA5A5_0002, 32'h1234_0001, 32'hDEAD_0000};

    netctl_regwin dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_be_i    (req_be),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .rsp_rdata_o (rsp_rdata),
        .spc_wr_o    (spc_wr),
        .spc_wdata_o (spc_wdata),
        .spc_rdata_i (spc_rdata),
        .wo_val_o    (wo_val)
    );

    // reference model
    logic [31:0] mdl [0:1023];

    localparam int K_SPC = 0, K_W1C = 1, K_RW = 2, K_WO = 3, K_RO = 4,
                   K_BASE = 5, K_PTR = 6, K_NONE = 7;

    function automatic int kind(input int i);
        if (i < 4)                          return K_SPC;
        if (i < 8)                          return K_W1C;
        if (i < 16)                         return K_RW;
        if (i < 20)                         return K_WO;
        if (i < 24)                         return K_RO;
        if (i >= 32 && i < 40)              return K_BASE;
        if (i >= 48 && i < 56)              return K_BASE;
        if (i >= 40 && i < 48)              return K_PTR;
        if (i >= 56 && i < 64)              return K_PTR;
        return K_NONE;
    endfunction

    function automatic logic [31:0] reset_val(input int i);
        case (i)
            4: return 32'h8000_00FF;  5: return 32'h0F0F_0F0F;  6: return 32'hFFFF_0000;
            8: return 32'h0000_1400;  9: return 32'h0040_05F2; 12: return 32'h0000_0600;
            20: return 32'h0124_0010; 21: return 32'h0000_0003; 22: return 32'hC0DE_0001;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            K_SPC:  return "R11";
            K_W1C:  return "R6";
            K_RW:   return "R4";
            K_WO:   return "R5";
            K_RO:   return "R7";
            K_BASE: return "R10";
            K_PTR:  return "R10";
            default: return "R8";
        endcase
    endfunction

    // expectation pipeline: nxt_* set by the driver, exp_* captured at the edge
    bit          nxt_valid = 0, exp_valid = 0;
    bit          nxt_err = 0,   exp_err = 0;
    logic [31:0] nxt_rdata = 0, exp_rdata = 0;
    logic [3:0]  nxt_strb = 0,  exp_strb = 0;
    logic [31:0] nxt_sdata = 0, exp_sdata = 0;
    string       nxt_tag = "R3", exp_tag = "R3";
    logic [127:0] exp_wo = '0;

    always @(posedge clk) begin
        exp_valid = nxt_valid; exp_err = nxt_err; exp_rdata = nxt_rdata;
        exp_strb = nxt_strb; exp_sdata = nxt_sdata; exp_tag = nxt_tag;
        exp_wo = {mdl[19], mdl[18], mdl[17], mdl[16]};
        nxt_valid = 0; nxt_err = 0; nxt_rdata = 0; nxt_strb = 0; nxt_sdata = 0; nxt_tag = "R3";
        cycles++;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("R3", 128'(rsp_valid), 128'(exp_valid), "rsp_valid");
            check(exp_err ? "R2" : "R3", 128'(rsp_err), 128'(exp_err), "rsp_err");
            if (exp_valid) check(exp_tag, 128'(rsp_rdata), 128'(exp_rdata), "rsp_rdata");
            check("R11", 128'(spc_wr), 128'(exp_strb), "spc_wr");
            if (exp_strb != 0) check("R11", 128'(spc_wdata), 128'(exp_sdata), "spc_wdata");
            check("R5", wo_val, exp_wo, "wo_val");
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) mdl[i] = reset_val(i);
    endtask

    task automatic access(input bit wr, input logic [15:0] addr, input logic [3:0] be, input logic [31:0] wd);
        int idx, k;
        bit bad;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
        idx = int'(addr >> 2);
        bad = (addr >= 16'h1000) || (addr[1:0] != 2'b00) || (be != 4'hF);
        nxt_valid = 1; nxt_err = bad; nxt_rdata = 0; nxt_strb = 0; nxt_sdata = 0;
        if (bad) begin
            nxt_tag = "R2";
        end else begin
            k = kind(idx);
            nxt_tag = tag_of(k);
            if (wr) begin
                case (k)
                    K_SPC:  begin nxt_strb = 4'(1 << idx); nxt_sdata = wd; end
                    K_W1C:  mdl[idx] = mdl[idx] & ~wd;
                    K_RW, K_WO, K_PTR: mdl[idx] = wd;
                    K_BASE: begin mdl[idx] = wd & 32'hFFFF_FFF8; mdl[idx + 8] = wd & 32'hFFFF_FFF8; end
                    default: ;
                endcase
            end else begin
                case (k)
                    K_SPC:  nxt_rdata = spc_rdata[idx*32 +: 32];
                    K_WO, K_NONE: nxt_rdata = 0;
                    default: nxt_rdata = mdl[idx];
                endcase
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input int i);  access(0, 16'(i * 4), 4'hF, 0); endtask
    task automatic wrw(input int i, input logic [31:0] v); access(1, 16'(i * 4), 4'hF, v); endtask

    initial begin : watchdog
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] lfsr;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;
        // R9 reset contents, R1 index mapping, R8 undefined reads
        for (int i = 0; i < 64; i++) rd(i);
        rd(100); rd(1023);
        idle();
        // R4 read-write and pointer
        wrw(8, 32'hDEAD_BEEF); rd(8); wrw(15, 32'h1234_5678); rd(15);
        wrw(41, 32'hCAFE_0007); rd(41);
        // R5 write-only
        wrw(16, 32'hAAAA_5555); wrw(19, 32'h0BAD_F00D); rd(16); rd(19); idle();
        // R6 write-one-to-clear
        wrw(4, 32'h8000_000F); rd(4); wrw(5, 32'h0000_0000); rd(5); wrw(6, 32'hFFFF_FFFF); rd(6);
        // R7 read-only, R8 undefined
        wrw(20, 32'hFFFF_FFFF); rd(20); wrw(25, 32'h1111_1111); rd(25); wrw(700, 32'h2); rd(700);
        // R10 base aliasing, tx and rx, override of direct pointer write
        wrw(32, 32'h1000_00FF); rd(32); rd(40);
        wrw(39, 32'h2222_2227); rd(39); rd(47);
        wrw(55, 32'h3333_3331); rd(55); rd(63);
        wrw(56, 32'h4444_4444); wrw(48, 32'h5555_555D); rd(56); rd(48);
        // R11 external words
        for (int s = 0; s < 4; s++) begin wrw(s, 32'h0F00_0000 + s); rd(s); end
        idle();
        // R2 rejects
        access(1, 16'h1000, 4'hF, 32'h9); access(1, 16'hFFFC, 4'hF, 32'h9);
        access(1, 16'h0022, 4'hF, 32'h9); access(1, 16'h0020, 4'h7, 32'h9);
        access(1, 16'h0080, 4'hE, 32'h9); access(1, 16'h0001, 4'hF, 32'h9);
        access(0, 16'h2000, 4'hF, 0);
        rd(8); rd(32); rd(40);
        // mixed run against the model
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 1500; n++) begin
            logic [15:0] a;
            logic [3:0]  b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (lfsr[3:0] == 0) ? lfsr[31:16] : {8'h00, lfsr[11:6], 2'b00};
            if (lfsr[5:4] == 0) a[1:0] = lfsr[13:12];
            b = (lfsr[27:25] == 0) ? lfsr[31:28] : 4'hF;
            if (lfsr[14:13] == 0) idle();
            else access(lfsr[20], a, b, {lfsr[15:0], lfsr[31:16]} ^ 32'h0000_0003);
        end
        idle(); idle(); idle();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule